// File: doc/BRIEF.md
# OTP Program Memory Access Controller

This block controls a one-time-programmable code store during device programming and readback. It has a programming side and a verify side. On the programming side an address, a data byte and a mode code are presented, and the active-low program strobe is pulsed. After the required number of strobe pulses the byte is committed to one of three targets: the code array, the 64-byte encryption array, or one of three security bits. Every commit can only clear bits, because the storage is one-time-programmable.

On the verify side the block returns code bytes scrambled through the encryption array, or fixed identification bytes. The encryption array itself never appears on the output. The security bits build up in steps. The first one freezes the code and encryption arrays and blocks table reads issued from external code. The first two together also blank the verify path. All three together also forbid execution from external program memory.

The storage is modelled as behavioural register arrays. Reset returns them to the unprogrammed all-ones state.

Top module: `otp_prog_ctrl`

## Requirements
- R1: Mode codes on `mode_i`: 0 idle, 1 write code, 2 write encryption, 3 write security bit, 4 verify, 5 signature. In a write mode a commit happens at the clock edge that samples the 5th high-to-low transition of `prog_n_i`, provided mode, address and data stayed unchanged since the first transition. `done_o` is high for the one cycle after that edge, and `busy_o` is high while a partial count is held.
- R2: A write mode left before the 5th transition, or a change of mode, address or data while a count is held, discards the partial operation. `busy_o` then drops, and nothing is written.
- R3: A committed code or encryption write stores old AND new, so bits can only go from 1 to 0.
- R4: In verify mode, `data_o` on the cycle after the request is the bitwise XNOR of the code byte with the encryption byte selected by the address. An all-ones encryption byte therefore returns the raw code byte. In idle mode `data_o` reads FFh.
- R5: The encryption byte is chosen by the low 6 address bits, so the 64 bytes repeat across the code space.
- R6: Security bits are chosen by `addr_i[1:0]` (0, 1 or 2). A selector value of 3 has no effect. Once any security bit is set, code and encryption writes are rejected, but the other security bits can still be set.
- R7: With security bits 0 and 1 both set, verify mode returns FFh.
- R8: `movc_ok_o` (table reads from external code may reach internal bytes) is low whenever security bit 0 is set.
- R9: `ext_exec_ok_o` is low once all three security bits are set, and is high otherwise.
- R10: Signature mode returns 15h at address 30h and the `DEV_CODE` parameter (default CBh) at 31h. Every other address returns FFh. This holds at every lock level.
- R11: After reset, `data_o`=FFh, `busy_o`=0, `done_o`=0, `movc_ok_o`=1 and `ext_exec_ok_o`=1, and all storage is unprogrammed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Operation code (see R1) |
| addr_i | input | ADDR_W | Byte address or security-bit selector |
| data_i | input | 8 | Byte to program |
| prog_n_i | input | 1 | Active-low program strobe, synchronous |
| data_o | output | 8 | Registered verify/signature byte |
| busy_o | output | 1 | A partial strobe count is held |
| done_o | output | 1 | One-cycle pulse after a commit |
| movc_ok_o | output | 1 | External table reads may fetch internal code |
| ext_exec_ok_o | output | 1 | Execution from external memory allowed |

## Verification
The assertions assume that `prog_n_i` is already synchronous to `clk` and that `mode_i` only takes the six defined codes. They also assume reset is held across at least one clock edge, so that the history used by `$past` starts from reset values. The stimulus changes every input on the falling clock edge and uses only the defined mode codes. It lets a strobe count be broken deliberately only in the abort and short-count cases. Everything else keeps mode, address and data still for all five pulses.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        OM_IDLE     = 3'd0,
        OM_PGM_CODE = 3'd1,
        OM_PGM_ENC  = 3'd2,
        OM_PGM_SEC  = 3'd3,
        OM_VERIFY   = 3'd4,
        OM_SIG      = 3'd5
    } otp_mode_e;

    localparam int SEC_BITS = 3;

    typedef struct packed {
        logic code_we;
        logic enc_we;
        logic sec_we;
    } otp_wr_t;

    typedef struct packed {
        logic wr_lock;
        logic verify_lock;
        logic movc_ok;
        logic exec_ok;
    } otp_perm_t;

    function automatic logic is_write_mode(input otp_mode_e m);
        return (m == OM_PGM_CODE) || (m == OM_PGM_ENC) || (m == OM_PGM_SEC);
    endfunction

    function automatic logic [7:0] scramble(input logic [7:0] code, input logic [7:0] key);
        return ~(code ^ key);
    endfunction

endpackage

// File: rtl/otp_strobe_seq.sv
module otp_strobe_seq
    import otp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PULSES = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  otp_mode_e         mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    input  logic              prog_n,
    output logic              fire,
    output logic              busy
);
    localparam int CNT_W = $clog2(PULSES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSES - 1);

    logic              prev_q;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    otp_mode_e         lat_mode;
    logic [ADDR_W-1:0] lat_addr;
    logic [7:0]        lat_data;
    logic              fall, same;

    assign fall = prev_q & ~prog_n;
    assign same = (mode == lat_mode) && (addr == lat_addr) && (data == lat_data);

    always_comb begin
        cnt_n = cnt_q;
        fire  = 1'b0;
        if (!is_write_mode(mode)) begin
            cnt_n = '0;
        end else if ((cnt_q != '0) && !same) begin
            cnt_n = fall ? CNT_W'(1) : '0;
        end else if (fall) begin
            if (cnt_q == LAST) begin
                fire  = 1'b1;
                cnt_n = '0;
            end else begin
                cnt_n = cnt_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b1;
            cnt_q    <= '0;
            lat_mode <= OM_IDLE;
            lat_addr <= '0;
            lat_data <= '0;
        end else begin
            prev_q <= prog_n;
            cnt_q  <= cnt_n;
            if (fall && is_write_mode(mode)) begin
                lat_mode <= mode;
                lat_addr <= addr;
                lat_data <= data;
            end
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/otp_store.sv
module otp_store #(
    parameter int ADDR_W    = 8,
    parameter int ENC_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              code_we,
    input  logic              enc_we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        code_rd,
    output logic [7:0]        enc_rd
);
    localparam int CODE_DEPTH = 1 << ADDR_W;
    localparam int ENC_W      = $clog2(ENC_DEPTH);

    logic [7:0] code_mem [CODE_DEPTH];
    logic [7:0] enc_mem  [ENC_DEPTH];

    logic [ENC_W-1:0] enc_wi, enc_ri;
    assign enc_wi = waddr[ENC_W-1:0];
    assign enc_ri = raddr[ENC_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CODE_DEPTH; i++) code_mem[i] <= 8'hFF;
        end else if (code_we) begin
            code_mem[waddr] <= code_mem[waddr] & wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENC_DEPTH; i++) enc_mem[i] <= 8'hFF;
        end else if (enc_we) begin
            enc_mem[enc_wi] <= enc_mem[enc_wi] & wdata;
        end
    end

    assign code_rd = code_mem[raddr];
    assign enc_rd  = enc_mem[enc_ri];

endmodule

// File: rtl/otp_sec_lock.sv
module otp_sec_lock
    import otp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sec_we,
    input  logic [1:0]          sel,
    output logic [SEC_BITS-1:0] sec_q,
    output otp_perm_t           perm
);
    generate
        for (genvar b = 0; b < SEC_BITS; b++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst) begin
                    sec_q[b] <= 1'b0;
                end else if (sec_we && (sel == 2'(b))) begin
                    sec_q[b] <= 1'b1;
                end
            end
        end
    endgenerate

    always_comb begin
        perm.wr_lock     = |sec_q;
        perm.movc_ok     = ~sec_q[0];
        perm.verify_lock = sec_q[0] & sec_q[1];
        perm.exec_ok     = ~(&sec_q);
    end

endmodule

// File: rtl/otp_read_path.sv
module otp_read_path
    import otp_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter logic [7:0] DEV_CODE = 8'hCB
) (
    input  logic              clk,
    input  logic              rst,
    input  otp_mode_e         mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        code_rd,
    input  logic [7:0]        enc_rd,
    input  logic              verify_lock,
    output logic [7:0]        data_o
);
    localparam logic [ADDR_W-1:0] SIG_MFR_A = ADDR_W'(8'h30);
    localparam logic [ADDR_W-1:0] SIG_DEV_A = ADDR_W'(8'h31);
    localparam logic [7:0]        MFR_CODE  = 8'h15;

    logic [7:0] next_byte;

    always_comb begin
        next_byte = 8'hFF;
        case (mode)
            OM_VERIFY: next_byte = verify_lock ? 8'hFF : scramble(code_rd, enc_rd);
            OM_SIG: begin
                if (addr == SIG_MFR_A)      next_byte = MFR_CODE;
                else if (addr == SIG_DEV_A) next_byte = DEV_CODE;
            end
            default: next_byte = 8'hFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) data_o <= 8'hFF;
        else     data_o <= next_byte;
    end

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
    import otp_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter int         ENC_DEPTH = 64,
    parameter int         PULSES    = 5,
    parameter logic [7:0] DEV_CODE  = 8'hCB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    input  logic              prog_n_i,
    output logic [7:0]        data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              movc_ok_o,
    output logic              ext_exec_ok_o
);
    otp_mode_e           mode;
    logic                fire;
    otp_wr_t             wr;
    otp_perm_t           perm;
    logic [SEC_BITS-1:0] sec_q;
    logic [7:0]          code_rd, enc_rd;
    logic                done_q;

    assign mode = otp_mode_e'(mode_i);

    otp_strobe_seq #(.ADDR_W(ADDR_W), .PULSES(PULSES)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .addr   (addr_i),
        .data   (data_i),
        .prog_n (prog_n_i),
        .fire   (fire),
        .busy   (busy_o)
    );

    always_comb begin
        wr.code_we = fire && (mode == OM_PGM_CODE) && !perm.wr_lock;
        wr.enc_we  = fire && (mode == OM_PGM_ENC)  && !perm.wr_lock;
        wr.sec_we  = fire && (mode == OM_PGM_SEC);
    end

    otp_store #(.ADDR_W(ADDR_W), .ENC_DEPTH(ENC_DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .code_we (wr.code_we),
        .enc_we  (wr.enc_we),
        .waddr   (addr_i),
        .wdata   (data_i),
        .raddr   (addr_i),
        .code_rd (code_rd),
        .enc_rd  (enc_rd)
    );

    otp_sec_lock u_lock (
        .clk    (clk),
        .rst    (rst),
        .sec_we (wr.sec_we),
        .sel    (addr_i[1:0]),
        .sec_q  (sec_q),
        .perm   (perm)
    );

    otp_read_path #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_rd (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .addr        (addr_i),
        .code_rd     (code_rd),
        .enc_rd      (enc_rd),
        .verify_lock (perm.verify_lock),
        .data_o      (data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= fire;
    end

    assign done_o        = done_q;
    assign movc_ok_o     = perm.movc_ok;
    assign ext_exec_ok_o = perm.exec_ok;

endmodule

// File: rtl/otp_prog_ctrl_chk.sv
module otp_prog_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] mode_i,
    input logic       prog_n_i,
    input logic [7:0] data_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       movc_ok_o,
    input logic       ext_exec_ok_o,
    input logic [2:0] sec_q
);
    // R1: a commit is always caused by a sampled low strobe
    p_done_on_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(prog_n_i) == 1'b0));

    // R1 / R2: the count is cleared by the commit
    p_idle_after_commit_r2: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R6: security bits never return to zero
    p_sec_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (($past(sec_q) & ~sec_q) == 3'b000));

    // R7: verify while bits 0 and 1 are set yields all ones
    p_verify_blank_r7: assert property (@(posedge clk) disable iff (rst)
        (($past(mode_i) == 3'd4) && $past(sec_q[0] & sec_q[1])) |-> (data_o == 8'hFF));

    // R8: table-read permission, once withdrawn, stays withdrawn
    p_movc_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !movc_ok_o |=> !movc_ok_o);

    // R9: execution permission, once withdrawn, stays withdrawn
    p_exec_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        !ext_exec_ok_o |=> !ext_exec_ok_o);

    // R8 / R9: losing execution rights implies losing table-read rights
    p_exec_implies_movc_r9: assert property (@(posedge clk) disable iff (rst)
        !ext_exec_ok_o |-> !movc_ok_o);

    // R4: idle mode reads all ones
    p_idle_reads_ff_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_i) == 3'd0) |-> (data_o == 8'hFF));

endmodule

bind otp_prog_ctrl otp_prog_ctrl_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .mode_i        (mode_i),
    .prog_n_i      (prog_n_i),
    .data_o        (data_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .movc_ok_o     (movc_ok_o),
    .ext_exec_ok_o (ext_exec_ok_o),
    .sec_q         (sec_q)
);

// File: tb/otp_prog_ctrl_tb_top.sv
`timescale 1ns/1ps
module otp_prog_ctrl_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst;
    logic [2:0] mode;
    logic [7:0] addr, din;
    logic       prog_n;
    logic [7:0] dout;
    logic       busy, done, movc_ok, exec_ok;

    otp_prog_ctrl dut_i (
        .clk(clk), .rst(rst), .mode_i(mode), .addr_i(addr), .data_i(din),
        .prog_n_i(prog_n), .data_o(dout), .busy_o(busy), .done_o(done),
        .movc_ok_o(movc_ok), .ext_exec_ok_o(exec_ok)
    );

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares data_o one cycle after each queued request
    always @(posedge clk) begin
        sb_item_t it;
        #2;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            check(dout === it.exp, it.tag, dout, it.exp);
        end
    end

    task automatic rd(input logic [2:0] m, input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        mode = m; addr = a; prog_n = 1'b1;
        sb_q.push_back('{exp: e, tag: tag});
    endtask

    task automatic drain();
        @(negedge clk);
        mode = 3'd0;
        @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); prog_n = 1'b0;
            @(negedge clk); prog_n = 1'b1;
        end
    endtask

    task automatic pgm(input logic [2:0] m, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        mode = m; addr = a; din = d; prog_n = 1'b1;
        pulses(4);
        @(negedge clk); prog_n = 1'b0;
        @(posedge clk); #2;
        check(done === 1'b1, "R1 done pulse", {7'd0, done}, 8'h01);
        check(busy === 1'b0, "R1 busy after commit", {7'd0, busy}, 8'h00);
        @(negedge clk); prog_n = 1'b1; mode = 3'd0;
        @(posedge clk); #2;
        check(done === 1'b0, "R1 done one cycle", {7'd0, done}, 8'h00);
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; mode = 3'd0; addr = 8'h00; din = 8'h00; prog_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #2;
        // R11 reset state
        check(dout === 8'hFF, "R11 data_o", dout, 8'hFF);
        check(busy === 1'b0, "R11 busy", {7'd0, busy}, 8'h00);
        check(done === 1'b0, "R11 done", {7'd0, done}, 8'h00);
        check(movc_ok === 1'b1, "R11 movc_ok", {7'd0, movc_ok}, 8'h01);
        check(exec_ok === 1'b1, "R11 exec_ok", {7'd0, exec_ok}, 8'h01);

        rd(3'd4, 8'h10, 8'hFF, "R11 blank code");
        rd(3'd0, 8'h10, 8'hFF, "R4 idle reads FF");
        drain();

        // R1, R4: program and read raw (encryption blank)
        pgm(3'd1, 8'h10, 8'hA5);
        rd(3'd4, 8'h10, 8'hA5, "R4 raw verify");
        drain();

        // R3: second write only clears bits
        pgm(3'd1, 8'h10, 8'h0F);
        rd(3'd4, 8'h10, 8'h05, "R3 AND write");
        drain();

        // R2: short count then leave write mode
        @(negedge clk); mode = 3'd1; addr = 8'h20; din = 8'h00; prog_n = 1'b1;
        pulses(4);
        @(posedge clk); #2;
        check(busy === 1'b1, "R1 busy during count", {7'd0, busy}, 8'h01);
        check(done === 1'b0, "R2 no done on 4 pulses", {7'd0, done}, 8'h00);
        @(negedge clk); mode = 3'd0;
        @(posedge clk); #2;
        check(busy === 1'b0, "R2 busy cleared on exit", {7'd0, busy}, 8'h00);
        rd(3'd4, 8'h20, 8'hFF, "R2 short count not written");
        drain();

        // R2: address change mid-count
        @(negedge clk); mode = 3'd1; addr = 8'h21; din = 8'h00; prog_n = 1'b1;
        pulses(3);
        @(negedge clk); addr = 8'h22;
        @(posedge clk); #2;
        check(busy === 1'b0, "R2 busy cleared on addr change", {7'd0, busy}, 8'h00);
        pgm(3'd1, 8'h22, 8'h00);
        rd(3'd4, 8'h21, 8'hFF, "R2 aborted addr untouched");
        rd(3'd4, 8'h22, 8'h00, "R2 new addr written");
        drain();

        // R10 signature
        rd(3'd5, 8'h30, 8'h15, "R10 manufacturer byte");
        rd(3'd5, 8'h31, 8'hCB, "R10 device byte");
        rd(3'd5, 8'h32, 8'hFF, "R10 other addr");
        drain();

        // R4, R5: encryption and aliasing
        pgm(3'd2, 8'h10, 8'h3C);
        rd(3'd4, 8'h10, 8'hC6, "R4 xnor verify");
        rd(3'd4, 8'h50, 8'h3C, "R5 alias low 6 bits");
        drain();

        // R6: selector 3 ignored
        pgm(3'd3, 8'h03, 8'h00);
        @(posedge clk); #2;
        check(movc_ok === 1'b1, "R6 selector 3 no effect", {7'd0, movc_ok}, 8'h01);
        pgm(3'd1, 8'h12, 8'h77);
        rd(3'd4, 8'h12, 8'h77, "R6 still writable");
        drain();

        // R6, R8: first security bit
        pgm(3'd3, 8'h00, 8'h00);
        @(posedge clk); #2;
        check(movc_ok === 1'b0, "R8 movc blocked", {7'd0, movc_ok}, 8'h00);
        check(exec_ok === 1'b1, "R9 exec still ok", {7'd0, exec_ok}, 8'h01);
        pgm(3'd1, 8'h11, 8'h00);
        rd(3'd4, 8'h11, 8'hFF, "R6 code write rejected");
        drain();
        pgm(3'd2, 8'h11, 8'h00);
        rd(3'd4, 8'h11, 8'hFF, "R6 enc write rejected");
        rd(3'd4, 8'h10, 8'hC6, "R7 verify ok with one bit");
        drain();

        // R7: second bit blanks verify; signature stays
        pgm(3'd3, 8'h01, 8'h00);
        rd(3'd4, 8'h10, 8'hFF, "R7 verify blanked");
        rd(3'd5, 8'h30, 8'h15, "R10 signature under lock");
        drain();
        @(posedge clk); #2;
        check(exec_ok === 1'b1, "R9 exec ok with two bits", {7'd0, exec_ok}, 8'h01);

        // R9: third bit
        pgm(3'd3, 8'h02, 8'h00);
        @(posedge clk); #2;
        check(exec_ok === 1'b0, "R9 exec blocked", {7'd0, exec_ok}, 8'h00);
        check(movc_ok === 1'b0, "R8 movc still blocked", {7'd0, movc_ok}, 8'h00);
        rd(3'd5, 8'h31, 8'hCB, "R10 device byte fully locked");
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule